// File: doc/BRIEF.md
# Timed Parallel ROM Read Sequencer

This block sits on the host side of an asynchronous parallel ROM with a word-wide data bus. A client raises a one-cycle request with a word address. The sequencer then drives the address, pulls the active-low chip select and the active-low output gate, and waits for the access times. It captures the returned word and hands it back with a one-cycle valid strobe. All waits are counted in clock cycles. They are worked out at elaboration from access times given in picoseconds and from the clock period, rounding up.

The ROM needs two separate waits: one from a stable address and active chip select, and a shorter one from the falling output gate. The sequencer lowers the output gate late, so that both waits end on the same sampling edge. After it lets go of the ROM, it keeps its ready output low for a turnaround gap. This covers the time in which the ROM's output drivers may still be on, so no other device may be enabled during that window. Between accesses the chip select stays high, which leaves the ROM in standby.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: The output gate `rom_oe_n_o` is never low while the chip select `rom_ce_n_o` is high. A word is captured only while both are low.
- R2: The captured word appears on `rd_data_o` in the cycle where `rd_valid_o` is high. `rd_valid_o` is a single-cycle pulse. With the default `HOLD_RDATA=1`, `rd_data_o` keeps the last captured word until the next capture.
- R3: A request is accepted on a rising edge where `req_i` and `ready_o` are both high. `rom_ce_n_o` goes low on that edge. The capture happens S edges later, where S = max(ceil(T_ACC_PS/CLK_PERIOD_PS), ceil(T_OE_PS/CLK_PERIOD_PS), 1). At that capture edge `rom_ce_n_o` returns high.
- R4: `rom_oe_n_o` goes low on the edge S-O after acceptance, where O = max(ceil(T_OE_PS/CLK_PERIOD_PS), 1). This gives exactly O cycles of output-gate time at the capture edge.
- R5: `rom_addr_o` takes `addr_i` on the accepting edge. It holds that value unchanged while the chip select is low and until the next acceptance.
- R6: `rom_ce_n_o` and `rom_oe_n_o` rise on the capture edge. `ready_o` then stays low for F = ceil(T_FLOAT_PS/CLK_PERIOD_PS) more cycles and is high again after edge S+F.
- R7: `ready_o` is low from the accepting edge until the gap ends. A request raised while `ready_o` is low is ignored: it causes no address change and no extra valid pulse.
- R8: After reset, and whenever idle, `ready_o` is 1 and both `rom_ce_n_o` and `rom_oe_n_o` are 1. Reset also clears `rd_valid_o` and `rd_data_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Read request, taken when ready_o is high |
| addr_i | input | ADDR_W | Word address of the request |
| ready_o | output | 1 | High when a new request can be accepted |
| rd_data_o | output | DATA_W | Captured word |
| rd_valid_o | output | 1 | One-cycle strobe marking a new captured word |
| rom_addr_o | output | ADDR_W | Address driven to the ROM |
| rom_ce_n_o | output | 1 | Active-low chip select to the ROM |
| rom_oe_n_o | output | 1 | Active-low output gate to the ROM |
| rom_data_i | input | DATA_W | Data bus from the ROM |

## Verification
The bench's ROM model returns the true word only after the chip select, the output gate and the address have each met their own nanosecond access time. Otherwise it returns a marker value. A capture one cycle early therefore shows up as a wrong word, not just a wrong strobe. Isolated requests at the address extremes, separated by long idle gaps, check standby and the basic timing. A request held high with a new address every cycle mixes requests raised while busy with requests taken on the first ready cycle. This separates correct hold-off and turnaround from accepting too early or latching a stray address.

// File: rtl/eprom_rd_pkg.sv
`timescale 1ns/1ps
package eprom_rd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACCESS = 2'd1,
      ST_FLOAT  = 2'd2
   } rd_state_e;

   // Round-up division used to turn picosecond times into cycle counts.
   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/eprom_rd_timer.sv
`timescale 1ns/1ps
module eprom_rd_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             run_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             zero_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (run_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign cnt_o  = cnt_q;
   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/eprom_rd_seq.sv
`timescale 1ns/1ps
module eprom_rd_seq
   import eprom_rd_pkg::*;
#(
   parameter int SAMPLE_CYC = 4,
   parameter int OE_CYC     = 2,
   parameter int FLOAT_CYC  = 2,
   parameter int CNT_W      = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_i,
   output logic accept_o,
   output logic capture_o,
   output logic ready_o,
   output logic ce_n_o,
   output logic oe_n_o
);

   localparam logic [CNT_W-1:0] LdAccess  = CNT_W'(SAMPLE_CYC - 1);
   localparam logic [CNT_W-1:0] LdFloat   = (FLOAT_CYC > 0) ? CNT_W'(FLOAT_CYC - 1) : '0;
   localparam logic [CNT_W-1:0] OeMark    = CNT_W'(OE_CYC);
   localparam bit               OeAtStart = (OE_CYC >= SAMPLE_CYC);

   rd_state_e        state_q;
   logic [CNT_W-1:0] cnt;
   logic             cnt_zero;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_run;
   logic             ce_n_q;
   logic             oe_n_q;

   assign ready_o   = (state_q == ST_IDLE);
   assign accept_o  = ready_o & req_i;
   assign capture_o = (state_q == ST_ACCESS) && cnt_zero;
   assign tmr_load  = accept_o | capture_o;
   assign tmr_val   = accept_o ? LdAccess : LdFloat;
   assign tmr_run   = (state_q != ST_IDLE);

   eprom_rd_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .run_i      (tmr_run),
      .cnt_o      (cnt),
      .zero_o     (cnt_zero)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         ce_n_q  <= 1'b1;
         oe_n_q  <= 1'b1;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept_o) begin
                  state_q <= ST_ACCESS;
                  ce_n_q  <= 1'b0;
                  oe_n_q  <= ~OeAtStart;
               end
            end
            ST_ACCESS: begin
               if (cnt_zero) begin
                  ce_n_q  <= 1'b1;
                  oe_n_q  <= 1'b1;
                  state_q <= (FLOAT_CYC > 0) ? ST_FLOAT : ST_IDLE;
               end else if (cnt == OeMark) begin
                  oe_n_q  <= 1'b0;
               end
            end
            ST_FLOAT: begin
               if (cnt_zero) begin
                  state_q <= ST_IDLE;
               end
            end
            default: begin
               state_q <= ST_IDLE;
               ce_n_q  <= 1'b1;
               oe_n_q  <= 1'b1;
            end
         endcase
      end
   end

   assign ce_n_o = ce_n_q;
   assign oe_n_o = oe_n_q;

   p_oe_within_ce_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !oe_n_q |-> !ce_n_q)
      else $error("output gate low while chip select high");

   p_busy_after_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && ready_o) |=> !ready_o)
      else $error("ready stayed high after an accepted request");

   p_standby_when_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_o |-> (ce_n_q && oe_n_q))
      else $error("ROM enabled while idle");

endmodule

// File: rtl/eprom_rd_dpath.sv
`timescale 1ns/1ps
module eprom_rd_dpath #(
   parameter int ADDR_W     = 18,
   parameter int DATA_W     = 16,
   parameter bit HOLD_RDATA = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              accept_i,
   input  logic              capture_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] rom_data_i,
   output logic [ADDR_W-1:0] rom_addr_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_valid_o
);

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              valid_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         addr_q  <= '0;
         data_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= capture_i;
         if (accept_i) begin
            addr_q <= addr_i;
         end
         if (capture_i) begin
            data_q <= rom_data_i;
         end
      end
   end

   assign rom_addr_o = addr_q;
   assign rd_valid_o = valid_q;

   generate
      if (HOLD_RDATA) begin : g_hold
         assign rd_data_o = data_q;

         p_rdata_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !rd_valid_o |-> $stable(rd_data_o))
            else $error("read data moved without a valid strobe");
      end else begin : g_mask
         assign rd_data_o = valid_q ? data_q : '0;
      end
   endgenerate

endmodule

// File: rtl/eprom_rd_ctrl.sv
`timescale 1ns/1ps
module eprom_rd_ctrl
   import eprom_rd_pkg::*;
#(
   parameter int ADDR_W        = 18,
   parameter int DATA_W        = 16,
   parameter int CLK_PERIOD_PS = 20000,
   parameter int T_ACC_PS      = 70000,
   parameter int T_OE_PS       = 35000,
   parameter int T_FLOAT_PS    = 30000,
   parameter bit HOLD_RDATA    = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              ready_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_valid_o,
   output logic [ADDR_W-1:0] rom_addr_o,
   output logic              rom_ce_n_o,
   output logic              rom_oe_n_o,
   input  logic [DATA_W-1:0] rom_data_i
);

   localparam int AccCyc    = ceil_div(T_ACC_PS, CLK_PERIOD_PS);
   localparam int OeCyc     = max2(ceil_div(T_OE_PS, CLK_PERIOD_PS), 1);
   localparam int SampleCyc = max2(max2(AccCyc, OeCyc), 1);
   localparam int FloatCyc  = ceil_div(T_FLOAT_PS, CLK_PERIOD_PS);
   localparam int CntW      = max2($clog2(max2(SampleCyc, FloatCyc) + 1), 1);

   generate
      if (CLK_PERIOD_PS < 1) begin : g_bad_clk
         $error("CLK_PERIOD_PS must be positive");
      end
      if ((ADDR_W < 1) || (DATA_W < 1)) begin : g_bad_width
         $error("ADDR_W and DATA_W must be positive");
      end
      if ((T_ACC_PS < 0) || (T_OE_PS < 0) || (T_FLOAT_PS < 0)) begin : g_bad_time
         $error("timing parameters must not be negative");
      end
   endgenerate

   logic accept;
   logic capture;

   eprom_rd_seq #(
      .SAMPLE_CYC (SampleCyc),
      .OE_CYC     (OeCyc),
      .FLOAT_CYC  (FloatCyc),
      .CNT_W      (CntW)
   ) u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (req_i),
      .accept_o  (accept),
      .capture_o (capture),
      .ready_o   (ready_o),
      .ce_n_o    (rom_ce_n_o),
      .oe_n_o    (rom_oe_n_o)
   );

   eprom_rd_dpath #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .HOLD_RDATA (HOLD_RDATA)
   ) u_dpath (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .accept_i   (accept),
      .capture_i  (capture),
      .addr_i     (addr_i),
      .rom_data_i (rom_data_i),
      .rom_addr_o (rom_addr_o),
      .rd_data_o  (rd_data_o),
      .rd_valid_o (rd_valid_o)
   );

   p_addr_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rom_ce_n_o && $past(!rom_ce_n_o)) |-> $stable(rom_addr_o))
      else $error("ROM address moved during an access");

   p_single_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_valid_o |=> !rd_valid_o)
      else $error("valid strobe longer than one cycle");

   p_release_on_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_valid_o |-> (rom_ce_n_o && rom_oe_n_o))
      else $error("ROM still enabled in the valid cycle");

   generate
      if (FloatCyc > 0) begin : g_gap_chk
         p_float_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(rom_oe_n_o) |-> !ready_o)
            else $error("ready rose with no turnaround gap");
      end
   endgenerate

endmodule

// File: tb/eprom_rd_ctrl_tb.sv
`timescale 1ns/1ps
module eprom_rd_ctrl_tb;

   localparam int CLK_NS = 20;
   localparam int ACC_NS = 70;
   localparam int OE_NS  = 35;
   localparam int FLT_NS = 30;
   localparam int ACC_C  = (ACC_NS + CLK_NS - 1) / CLK_NS;
   localparam int OE_C   = (OE_NS + CLK_NS - 1) / CLK_NS;
   localparam int FLT_C  = (FLT_NS + CLK_NS - 1) / CLK_NS;
   localparam int SMP    = (ACC_C > OE_C) ? ACC_C : OE_C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [17:0] addr = '0;
   logic        ready;
   logic [15:0] rd_data;
   logic        rd_valid;
   logic [17:0] rom_addr;
   logic        rom_ce_n;
   logic        rom_oe_n;
   logic [15:0] rom_data = 16'h0F0F;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  run_chk = 1'b0;
   bit  finished = 1'b0;

   always #(CLK_NS / 2) clk = ~clk;

   eprom_rd_ctrl #(
      .ADDR_W        (18),
      .DATA_W        (16),
      .CLK_PERIOD_PS (CLK_NS * 1000),
      .T_ACC_PS      (ACC_NS * 1000),
      .T_OE_PS       (OE_NS * 1000),
      .T_FLOAT_PS    (FLT_NS * 1000),
      .HOLD_RDATA    (1'b1)
   ) u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .req_i      (req),
      .addr_i     (addr),
      .ready_o    (ready),
      .rd_data_o  (rd_data),
      .rd_valid_o (rd_valid),
      .rom_addr_o (rom_addr),
      .rom_ce_n_o (rom_ce_n),
      .rom_oe_n_o (rom_oe_n),
      .rom_data_i (rom_data)
   );

   function automatic logic [15:0] rom_word(input logic [17:0] a);
      return a[15:0] ^ {a[17:16], a[17:16], 12'h5A3};
   endfunction

   // ROM model with its three access times in nanoseconds.
   time t_ce = 0;
   time t_oe = 0;
   time t_adr = 0;
   always @(negedge rom_ce_n) t_ce = $time;
   always @(negedge rom_oe_n) t_oe = $time;
   always @(rom_addr) t_adr = $time;
   always begin
      #1;
      if (!rom_ce_n && !rom_oe_n) begin
         if (($time - t_ce >= ACC_NS) && ($time - t_oe >= OE_NS) && ($time - t_adr >= ACC_NS))
            rom_data = rom_word(rom_addr);
         else
            rom_data = 16'hBAD0;
      end else begin
         rom_data = 16'h0F0F;
      end
   end

   // Reference model: cycles since acceptance.
   bit          m_busy = 1'b0;
   int          m_t = 0;
   logic [17:0] m_addr = '0;
   logic [15:0] e_rdata = '0;
   bit          e_rvalid = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 1'b0; m_t = 0; m_addr = '0; e_rdata = '0; e_rvalid = 1'b0;
      end else begin
         e_rvalid = 1'b0;
         if (!m_busy) begin
            if (req) begin
               m_busy = 1'b1; m_t = 0; m_addr = addr;
            end
         end else begin
            m_t++;
            if (m_t == SMP) begin
               e_rvalid = 1'b1;
               e_rdata  = rom_word(m_addr);
            end
            if (m_t == SMP + FLT_C) m_busy = 1'b0;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && run_chk && !finished) begin
         chk("R3 chip select timing", 32'(rom_ce_n), 32'(!(m_busy && m_t < SMP)));
         chk("R4 output gate timing", 32'(rom_oe_n), 32'(!(m_busy && m_t >= SMP - OE_C && m_t < SMP)));
         if (!rom_oe_n) chk("R1 gate only under select", 32'(rom_ce_n), 32'd0);
         chk("R2 valid strobe", 32'(rd_valid), 32'(e_rvalid));
         chk("R2 read data", 32'(rd_data), 32'(e_rdata));
         chk("R5 address hold", 32'(rom_addr), 32'(m_addr));
         if (m_busy && m_t >= SMP)
            chk("R6 turnaround ready", 32'(ready), 32'(!m_busy));
         else
            chk("R7 ready hold-off", 32'(ready), 32'(!m_busy));
         if (!m_busy) chk("R8 standby when idle", 32'({rom_ce_n, rom_oe_n}), 32'd3);
      end
   end

   task automatic single_read(input logic [17:0] a, input int gap);
      @(negedge clk);
      req = 1'b1; addr = a;
      @(negedge clk);
      req = 1'b0; addr = ~a;
      repeat (SMP + FLT_C + gap) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset values
      chk("R8 reset ready", 32'(ready), 32'd1);
      chk("R8 reset chip select", 32'(rom_ce_n), 32'd1);
      chk("R8 reset output gate", 32'(rom_oe_n), 32'd1);
      chk("R8 reset valid", 32'(rd_valid), 32'd0);
      chk("R8 reset data", 32'(rd_data), 32'd0);
      rst_n = 1'b1;
      run_chk = 1'b1;
      single_read(18'h00000, 6);
      single_read(18'h3FFFF, 2);
      single_read(18'h12345, 0);
      single_read(18'h2AAAA, 4);
      // R7: request held high, new address every cycle; busy-time ones ignored
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         req  = 1'b1;
         addr = 18'(i * 7919 + 5);
      end
      @(negedge clk);
      req = 1'b0;
      repeat (SMP + FLT_C + 10) @(negedge clk);
      finish_run();
   end

   initial begin
      #(200000 * CLK_NS);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

endmodule